// File: doc/BRIEF.md
# Supervisor reset and watchdog controller

This block drives the single reset line of a host processor. It merges three causes of reset: the power-on interval after the block leaves its own reset, a supply-low indication from an external comparator, and a watchdog that expires when the host stops servicing it. The host services the watchdog by making any transition on a pin that doubles as the serial chip select. Any ordinary bus access toggles that pin, so active firmware keeps the watchdog quiet without a dedicated write.

Time is measured in ticks of a parameterised prescaler. The power-on interval is `POR_TICKS` ticks. The watchdog interval comes from a 2-bit selection input that is held in non-volatile storage outside the block: one of three tick counts, or off. Every cause of reset holds the output for the same power-on interval after the cause goes away. A volatile flag records whether the most recent reset came from the watchdog. Software clears the flag with a one-cycle strobe, and a supply-low event also clears it.

The two asynchronous inputs, `supply_ok` and `cs_wdi`, each pass through a two-stage synchroniser. P below is `PRESCALE`. In the timing stated in the requirements, an input change driven between clock edges is sampled at edge 1.

Top module: `sup_reset_ctrl`

## Requirements
- R1: While `rst` is high, `sys_reset` reads 1 and `wd_cause` reads 0 after the next clock edge.
- R2: With `supply_ok` held high, `sys_reset` stays 1 through edge POR_TICKS*P+1 after `rst` falls, and reads 0 after edge POR_TICKS*P+2.
- R3: When `supply_ok` falls, `sys_reset` is still unchanged after edge 2 and reads 1 after edge 3. It stays 1 for as long as `supply_ok` stays low.
- R4: When `supply_ok` rises again, `sys_reset` stays 1 through edge POR_TICKS*P+1 and reads 0 after edge POR_TICKS*P+2.
- R5: With no transition on `cs_wdi`, `sys_reset` rises exactly L*P cycles after it was released. L is WD_T0 for `wd_sel`=00, WD_T1 for 01 and WD_T2 for 10.
- R6: A rising or falling transition on `cs_wdi` while the output is released restarts the watchdog. Without a further transition, `sys_reset` rises at edge L*P+3 after that transition and not before.
- R7: With `wd_sel`=11 the watchdog never asserts `sys_reset`, however long `cs_wdi` stays still.
- R8: After a watchdog expiry, `sys_reset` stays 1 for exactly POR_TICKS*P cycles and then releases.
- R9: `wd_cause` is set to 1 at the same edge as a watchdog expiry. It reads 0 after the edge at which `flag_clr` is sampled high, unless an expiry happens at that same edge. It also reads 0 after the edge at which a supply-low event asserts `sys_reset`.
- R10: Transitions on `cs_wdi` while `sys_reset` is 1 change neither the hold length nor the watchdog interval that follows the release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the block |
| supply_ok | input | 1 | Asynchronous comparator output, 1 = supply above threshold |
| cs_wdi | input | 1 | Shared chip-select / watchdog service pin, asynchronous |
| wd_sel | input | 2 | Stored timeout selection: 00 short, 01 middle, 10 long, 11 off |
| flag_clr | input | 1 | One-cycle strobe that clears the watchdog cause flag |
| sys_reset | output | 1 | Registered reset to the host, 1 = asserted |
| wd_cause | output | 1 | 1 = the last reset was caused by watchdog expiry |

## Verification
The bench builds the block with PRESCALE=4, POR_TICKS=5 and watchdog counts 3, 6 and 10. The hold interval is therefore 20 cycles and the three timeouts are 12, 24 and 40 cycles. At these values every release and expiry edge can be checked to the exact cycle, and dozens of random kick trains, each with its own timeout and its own spacing between kicks, fit in a few thousand cycles. The prescaler's phase, the two-stage synchroniser latency and the reset of the prescaler on a kick all show up in these edge counts.

// File: rtl/sup_pkg.sv
package sup_pkg;

  // Stages of the input synchronisers; requirement timing assumes two.
  localparam int SYNC_STAGES = 2;

  typedef enum logic [1:0] {
    WD_SHORT = 2'b00,
    WD_MID   = 2'b01,
    WD_LONG  = 2'b10,
    WD_OFF   = 2'b11
  } wd_sel_e;

endpackage

// File: rtl/sup_sync.sv
module sup_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/sup_tick.sv
module sup_tick #(
  parameter int PRESCALE = 100000
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  output logic tick
);

  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

  logic [PW-1:0] cnt;

  assign tick = (cnt == PW'(PRESCALE - 1));

  always_ff @(posedge clk) begin
    if (rst || clear) cnt <= '0;
    else if (tick)    cnt <= '0;
    else              cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/sup_wdog.sv
module sup_wdog
  import sup_pkg::*;
#(
  parameter int T0 = 200,
  parameter int T1 = 600,
  parameter int T2 = 1400
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       hold,
  input  logic       kick,
  input  logic       tick,
  input  logic [1:0] sel,
  output logic       expire
);

  localparam int TMAX = (T0 > T1) ? ((T0 > T2) ? T0 : T2) : ((T1 > T2) ? T1 : T2);
  localparam int CW   = $clog2(TMAX + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;
  logic          en;
  logic          last;

  always_comb begin
    case (wd_sel_e'(sel))
      WD_SHORT: lim = CW'(T0);
      WD_MID:   lim = CW'(T1);
      WD_LONG:  lim = CW'(T2);
      default:  lim = '0;
    endcase
  end

  assign en     = (wd_sel_e'(sel) != WD_OFF);
  assign last   = (cnt == lim - 1'b1);
  assign expire = en && !hold && !kick && tick && last;

  always_ff @(posedge clk) begin
    if (rst || hold || kick) cnt <= '0;
    else if (tick && en) begin
      if (last) cnt <= '0;
      else      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/sup_reset_ctrl.sv
module sup_reset_ctrl
  import sup_pkg::*;
#(
  parameter int PRESCALE  = 100000,
  parameter int POR_TICKS = 800,
  parameter int WD_T0     = 200,
  parameter int WD_T1     = 600,
  parameter int WD_T2     = 1400
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       supply_ok,
  input  logic       cs_wdi,
  input  logic [1:0] wd_sel,
  input  logic       flag_clr,
  output logic       sys_reset,
  output logic       wd_cause
);

  localparam int HW = (POR_TICKS > 1) ? $clog2(POR_TICKS) : 1;

  logic [1:0]    sync_q;
  logic          supply_s;
  logic          cs_s;
  logic          cs_d;
  logic          kick;
  logic          tick;
  logic          wd_expire;
  logic          restart;
  logic          sys_reset_q;
  logic          cause_q;
  logic [HW-1:0] hold_cnt;

  sup_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({cs_wdi, supply_ok}),
    .q   (sync_q)
  );

  assign supply_s = sync_q[0];
  assign cs_s     = sync_q[1];

  always_ff @(posedge clk) begin
    if (rst) cs_d <= 1'b0;
    else     cs_d <= cs_s;
  end

  assign kick    = cs_s ^ cs_d;
  assign restart = !supply_s || wd_expire;

  sup_tick #(.PRESCALE(PRESCALE)) u_tick (
    .clk   (clk),
    .rst   (rst),
    .clear (restart || (kick && !sys_reset_q)),
    .tick  (tick)
  );

  sup_wdog #(.T0(WD_T0), .T1(WD_T1), .T2(WD_T2)) u_wdog (
    .clk    (clk),
    .rst    (rst),
    .hold   (sys_reset_q),
    .kick   (kick),
    .tick   (tick),
    .sel    (wd_sel),
    .expire (wd_expire)
  );

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      sys_reset_q <= 1'b1;
      hold_cnt    <= '0;
    end else if (sys_reset_q && tick) begin
      if (hold_cnt == HW'(POR_TICKS - 1)) begin
        sys_reset_q <= 1'b0;
        hold_cnt    <= '0;
      end else begin
        hold_cnt <= hold_cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                       cause_q <= 1'b0;
    else if (wd_expire)            cause_q <= 1'b1;
    else if (!supply_s || flag_clr) cause_q <= 1'b0;
  end

  assign sys_reset = sys_reset_q;
  assign wd_cause  = cause_q;

endmodule

// File: rtl/sup_reset_ctrl_chk.sv
module sup_reset_ctrl_chk #(
  parameter int POR_TICKS = 800,
  parameter int HW        = 10
) (
  input logic          clk,
  input logic          rst,
  input logic          supply_ok,
  input logic          flag_clr,
  input logic          sys_reset,
  input logic          wd_cause,
  input logic [HW-1:0] hold_cnt
);

  AST_RST_HOLD: assert property (@(posedge clk) rst |=> (sys_reset && !wd_cause)); // R1

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (32'(hold_cnt) < POR_TICKS)); // R2

  AST_SUPPLY_LOW: assert property (@(posedge clk) disable iff (rst)
    (!supply_ok && !$past(supply_ok) && !$past(supply_ok, 2)) |=> sys_reset); // R3

  AST_RELEASE_SUPPLY: assert property (@(posedge clk) disable iff (rst)
    $fell(sys_reset) |-> ($past(supply_ok) && $past(supply_ok, 2))); // R4

  AST_FLAG_WITH_RESET: assert property (@(posedge clk) disable iff (rst)
    $rose(wd_cause) |-> $rose(sys_reset)); // R9

  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (rst)
    flag_clr |=> (!wd_cause || $rose(sys_reset))); // R9

endmodule

bind sup_reset_ctrl sup_reset_ctrl_chk #(.POR_TICKS(POR_TICKS), .HW(HW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .supply_ok (supply_ok),
  .flag_clr  (flag_clr),
  .sys_reset (sys_reset),
  .wd_cause  (wd_cause),
  .hold_cnt  (hold_cnt)
);

// File: tb/tb_sup_reset_ctrl.sv
`timescale 1ns/1ps
module tb_sup_reset_ctrl;

  localparam int P   = 4;
  localparam int POR = 5;
  localparam int T0  = 3;
  localparam int T1  = 6;
  localparam int T2  = 10;

  logic       clk = 1'b0;
  logic       rst;
  logic       supply_ok;
  logic       cs_wdi;
  logic [1:0] wd_sel;
  logic       flag_clr;
  logic       sys_reset;
  logic       wd_cause;

  int n_cmp  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  sup_reset_ctrl #(
    .PRESCALE(P), .POR_TICKS(POR), .WD_T0(T0), .WD_T1(T1), .WD_T2(T2)
  ) dut (
    .clk(clk), .rst(rst), .supply_ok(supply_ok), .cs_wdi(cs_wdi),
    .wd_sel(wd_sel), .flag_clr(flag_clr), .sys_reset(sys_reset), .wd_cause(wd_cause)
  );

  function automatic int wd_cycles(int s);
    case (s)
      0:       return T0 * P;
      1:       return T1 * P;
      default: return T2 * P;
    endcase
  endfunction

  function automatic int hold_cycles();
    return POR * P;
  endfunction

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic chk(bit ok, string req, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_release(output int n);
    n = 0;
    while (sys_reset && n < 1000) begin
      step();
      n++;
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    int n;
    int lp;
    int s;
    void'($urandom(32'd7321));
    rst = 1'b1; supply_ok = 1'b1; cs_wdi = 1'b0; wd_sel = 2'b11; flag_clr = 1'b0;
    @(negedge clk);
    step(3);
    chk(sys_reset == 1'b1, "R1 reset out", int'(sys_reset), 1);
    chk(wd_cause == 1'b0, "R1 flag", int'(wd_cause), 0);

    // R2 power-on interval
    rst = 1'b0;
    step(hold_cycles() + 1);
    chk(sys_reset == 1'b1, "R2 still held", int'(sys_reset), 1);
    step();
    chk(sys_reset == 1'b0, "R2 released", int'(sys_reset), 0);

    // R7 watchdog disabled
    n = 0;
    for (int i = 0; i < 150; i++) begin
      step();
      if (sys_reset) n++;
    end
    chk(n == 0, "R7 no reset when off", n, 0);

    // R6 kick with short selection, then R8 hold, R9 flag
    wd_sel = 2'b00; cs_wdi = ~cs_wdi;
    lp = wd_cycles(0);
    step(lp + 2);
    chk(sys_reset == 1'b0, "R6 before expiry", int'(sys_reset), 0);
    step();
    chk(sys_reset == 1'b1, "R6 expiry edge", int'(sys_reset), 1);
    chk(wd_cause == 1'b1, "R9 flag set", int'(wd_cause), 1);
    // R10 toggles during hold are ignored
    step(); cs_wdi = ~cs_wdi;
    step(2); cs_wdi = ~cs_wdi;
    step(hold_cycles() - 4);
    chk(sys_reset == 1'b1, "R8 R10 still held", int'(sys_reset), 1);
    step();
    chk(sys_reset == 1'b0, "R8 R10 released", int'(sys_reset), 0);

    // R5 unserviced expiry from release, middle selection
    wd_sel = 2'b01;
    lp = wd_cycles(1);
    step(lp - 1);
    chk(sys_reset == 1'b0, "R5 before expiry", int'(sys_reset), 0);
    step();
    chk(sys_reset == 1'b1, "R5 expiry", int'(sys_reset), 1);
    wait_release(n);
    chk(n == hold_cycles(), "R8 hold length", n, hold_cycles());

    // R5 long selection
    wd_sel = 2'b10;
    lp = wd_cycles(2);
    step(lp - 1);
    chk(sys_reset == 1'b0, "R5 long before", int'(sys_reset), 0);
    step();
    chk(sys_reset == 1'b1, "R5 long expiry", int'(sys_reset), 1);
    wd_sel = 2'b11;
    wait_release(n);
    chk(wd_cause == 1'b1, "R9 flag held", int'(wd_cause), 1);

    // R3 supply drop clears flag, R4 return
    supply_ok = 1'b0;
    step(2);
    chk(sys_reset == 1'b0, "R3 not yet", int'(sys_reset), 0);
    step();
    chk(sys_reset == 1'b1, "R3 asserted", int'(sys_reset), 1);
    chk(wd_cause == 1'b0, "R9 flag cleared by supply", int'(wd_cause), 0);
    step(60);
    chk(sys_reset == 1'b1, "R3 held while low", int'(sys_reset), 1);
    supply_ok = 1'b1;
    step(hold_cycles() + 1);
    chk(sys_reset == 1'b1, "R4 still held", int'(sys_reset), 1);
    step();
    chk(sys_reset == 1'b0, "R4 released", int'(sys_reset), 0);

    // R9 software clear
    wd_sel = 2'b00;
    step(wd_cycles(0));
    chk(wd_cause == 1'b1, "R9 flag set again", int'(wd_cause), 1);
    flag_clr = 1'b1;
    step();
    flag_clr = 1'b0;
    chk(wd_cause == 1'b0, "R9 flag_clr", int'(wd_cause), 0);
    wait_release(n);

    // Random kick trains, R6 and R8
    for (int t = 0; t < 40; t++) begin
      int nk;
      s = int'($urandom_range(2, 0));
      wd_sel = 2'(s);
      lp = wd_cycles(s);
      nk = int'($urandom_range(3, 1));
      for (int k = 0; k < nk; k++) begin
        step(int'($urandom_range(lp - 4, (k == 0) ? 0 : 1)));
        cs_wdi = ~cs_wdi;
      end
      step(lp + 2);
      chk(sys_reset == 1'b0, "R6 random before", int'(sys_reset), 0);
      step();
      chk(sys_reset == 1'b1, "R6 random expiry", int'(sys_reset), 1);
      wait_release(n);
      chk(n == hold_cycles(), "R8 random hold", n, hold_cycles());
    end

    finish_run();
  end

endmodule